// File: doc/BRIEF.md
# Low Memory Chip Select Decoder

This block generates an active-low chip select for a region that always begins at physical address 00000h, the bottom of a 20-bit address space where the interrupt vector table lives. A processor programs a 16-bit control word through a simple write strobe. A 3-bit boundary field in that word picks one of four region sizes: 64 KB, 128 KB, 256 KB or 512 KB. Each bus address, qualified by an address-valid input, is then compared against that boundary.

The register holds no defined value after reset, so the decode is kept off by a two-state arming machine. It starts in `DISARMED`, where the chip select is held inactive. The `ARM` transition fires on any register write strobe, whatever data is written, and moves it to `ARMED`. It stays in `ARMED` until the next reset, which takes the `RESET` transition back to `DISARMED`. The whole control word is stored and can be read back. Only the boundary field affects the decode.

Top module: `lowmem_csel`

## Requirements
- R1: After a synchronous reset, `cs_n` stays high for every address and for `addr_valid` high or low, until the first register write.
- R2: Any register write, including the value 0000h, arms the decoder from the cycle after the write strobe is sampled. The decoder then stays armed until reset.
- R3: With the boundary field (control bits 14..12) at 000b, `cs_n` is low for addresses 00000h..0FFFFh and high above them.
- R4: With the boundary field at 001b, `cs_n` is low for addresses 00000h..1FFFFh and high above them.
- R5: With the boundary field at 011b, `cs_n` is low for addresses 00000h..3FFFFh and high above them.
- R6: With the boundary field at 111b, `cs_n` is low for addresses 00000h..7FFFFh and high above them. Address bit 19 always disqualifies.
- R7: Boundary codes 010b, 100b, 101b and 110b decode exactly like 000b (64 KB).
- R8: While `addr_valid` is low, `cs_n` is high whatever the address and state.
- R9: Control bits 15 and 11..0 do not change the decode. Two words with equal bits 14..12 give identical `cs_n` for every address.
- R10: `rd_data` equals the last written control word from the cycle after the write.
- R11: A reset asserted after arming returns the decoder to the disarmed state, so `cs_n` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Stored control word |
| addr | input | 20 | Bus address |
| addr_valid | input | 1 | Address qualifier, active high |
| cs_n | output | 1 | Low memory chip select, active low |

## Verification
The bench sweeps all eight boundary codes. For each code it tests every value of the top address nibble, with the low 16 address bits both all-zero and all-one, so every region edge is approached from both sides. A mask that is shifted by one bit would show up at those edges as a region that is doubled or halved. A design that passed unsupported codes through would widen the window on 010b or 1x0b. The bench also writes zero as the very first value, to catch an arming flag that was taken from the data rather than from the strobe. It writes words that differ only outside the boundary field, to catch decode logic that looks at the wrong bits. Finally, it resets after arming, to catch an armed state that survives reset.

// File: rtl/lmcs_pkg.sv
package lmcs_pkg;
    typedef enum logic {
        ST_DISARMED = 1'b0,
        ST_ARMED    = 1'b1
    } lmcs_state_e;
endpackage

// File: rtl/lmcs_arm_fsm.sv
module lmcs_arm_fsm
    import lmcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    output logic armed
);
    lmcs_state_e state_q, state_d;

    // transition logic: ARM on any write strobe, RESET handled in the register
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DISARMED: if (wr_en) state_d = ST_ARMED;
            ST_ARMED:    state_d = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_DISARMED;
        else     state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_DISARMED: armed = 1'b0;
            ST_ARMED:    armed = 1'b1;
        endcase
    end
endmodule

// File: rtl/lmcs_size_decode.sv
module lmcs_size_decode #(
    parameter int CODE_W  = 3,
    parameter int UPPER_W = 4
) (
    input  logic [CODE_W-1:0]  code,
    output logic [UPPER_W-1:0] keep_mask
);
    // A keep bit of 1 means that upper address bit must be zero for a hit.
    // Only thermometer codes (k low ones) widen the window; anything else is the base size.
    always_comb begin
        keep_mask = {UPPER_W{1'b1}};
        for (int k = 1; k <= CODE_W; k++) begin
            if (code == CODE_W'((1 << k) - 1))
                keep_mask = ~UPPER_W'((1 << k) - 1);
        end
    end
endmodule

// File: rtl/lmcs_addr_match.sv
module lmcs_addr_match #(
    parameter int UPPER_W = 4
) (
    input  logic [UPPER_W-1:0] upper_addr,
    input  logic [UPPER_W-1:0] keep_mask,
    output logic               hit
);
    logic [UPPER_W-1:0] bit_ok;

    genvar i;
    generate
        for (i = 0; i < UPPER_W; i++) begin : g_bit
            assign bit_ok[i] = ~(upper_addr[i] & keep_mask[i]);
        end
    endgenerate

    assign hit = &bit_ok;
endmodule

// File: rtl/lowmem_csel.sv
module lowmem_csel #(
    parameter int ADDR_W     = 20,
    parameter int REG_W      = 16,
    parameter int BASE_LOG2  = 16,
    parameter int BOUND_LSB  = 12,
    parameter int BOUND_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_valid,
    output logic              cs_n
);
    localparam int UPPER_W = ADDR_W - BASE_LOG2;

    logic [REG_W-1:0]   ctrl_q;
    logic [BOUND_W-1:0] code_w;
    logic [UPPER_W-1:0] keep_w;
    logic               armed_w;
    logic               hit_w;

    // contents are undefined until written; the arming state gates their use
    always_ff @(posedge clk) begin
        if (wr_en) ctrl_q <= wr_data;
    end

    assign rd_data = ctrl_q;
    assign code_w  = ctrl_q[BOUND_LSB +: BOUND_W];

    lmcs_arm_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .armed (armed_w)
    );

    lmcs_size_decode #(.CODE_W(BOUND_W), .UPPER_W(UPPER_W)) u_dec (
        .code      (code_w),
        .keep_mask (keep_w)
    );

    lmcs_addr_match #(.UPPER_W(UPPER_W)) u_match (
        .upper_addr (addr[ADDR_W-1:BASE_LOG2]),
        .keep_mask  (keep_w),
        .hit        (hit_w)
    );

    assign cs_n = ~(addr_valid & armed_w & hit_w);
endmodule

// File: rtl/lmcs_checker.sv
module lmcs_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic [19:0] addr,
    input logic        addr_valid,
    input logic        cs_n,
    input logic        armed,
    input logic [2:0]  code
);
    a_r1_off_when_disarmed: assert property (@(posedge clk) disable iff (rst)
        !armed |-> cs_n);

    a_r2_write_arms: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> armed);

    a_r2_stays_armed: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);

    a_r8_valid_gates: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> cs_n);

    a_r6_top_bound: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> (addr < 20'h80000));

    a_r7_base_size: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && code != 3'b001 && code != 3'b011 && code != 3'b111)
        |-> (addr[19:16] == 4'h0));

    a_r10_readback: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == $past(wr_data)));
endmodule

bind lowmem_csel lmcs_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .addr       (addr),
    .addr_valid (addr_valid),
    .cs_n       (cs_n),
    .armed      (armed_w),
    .code       (code_w)
);

// File: tb/lowmem_csel_bench.sv
module lowmem_csel_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [19:0] addr = '0;
    logic        addr_valid = 1'b0;
    logic        cs_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lowmem_csel u_lowmem_csel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .addr(addr), .addr_valid(addr_valid), .cs_n(cs_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_cs(input bit armed, input bit v, input logic [2:0] c,
                                    input logic [19:0] a);
        int k;
        k = (c == 3'b001) ? 1 : (c == 3'b011) ? 2 : (c == 3'b111) ? 3 : 0;
        return !(armed && v && (int'(a) < (32'h10000 << k)));
    endfunction

    task automatic write_reg(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // sweep upper nibble, both low-half extremes, both valid levels
    task automatic sweep(input bit armed, input logic [2:0] c, input string tag);
        for (int n = 0; n < 16; n++) begin
            for (int lo = 0; lo < 2; lo++) begin
                for (int v = 0; v < 2; v++) begin
                    addr = {n[3:0], (lo != 0) ? 16'hFFFF : 16'h0000};
                    addr_valid = v[0];
                    #1;
                    check(cs_n == exp_cs(armed, v[0], c, addr),
                          (v == 0) ? "R8" : tag, int'(cs_n),
                          int'(exp_cs(armed, v[0], c, addr)));
                end
            end
        end
        addr_valid = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_up();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        sweep(0, 3'b000, "R1");
        repeat (4) @(negedge clk);
        sweep(0, 3'b000, "R1");

        // R2: zero written first still arms
        write_reg(16'h0000);
        addr = 20'h00000; addr_valid = 1'b1; #1;
        check(cs_n == 1'b0, "R2", int'(cs_n), 0);
        check(rd_data == 16'h0000, "R10", int'(rd_data), 0);
        repeat (3) @(negedge clk);
        #1;
        check(cs_n == 1'b0, "R2", int'(cs_n), 0);

        for (int c = 0; c < 8; c++) begin
            string tag;
            d = {1'b0, c[2:0], 12'hA5C ^ 12'(c)};
            write_reg(d);
            #1;
            check(rd_data == d, "R10", int'(rd_data), int'(d));
            case (c)
                0: tag = "R3";
                1: tag = "R4";
                3: tag = "R5";
                7: tag = "R6";
                default: tag = "R7";
            endcase
            sweep(1, c[2:0], tag);
        end

        // R9: bits outside 14..12 have no effect
        write_reg(16'h9FFF);
        #1;
        check(rd_data == 16'h9FFF, "R9", int'(rd_data), 16'h9FFF);
        sweep(1, 3'b001, "R9");
        write_reg(16'h3000);
        sweep(1, 3'b011, "R9");
        write_reg(16'hBFFF);
        sweep(1, 3'b011, "R9");

        // R11: reset after arming disarms
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        sweep(0, 3'b011, "R11");

        finish_up();
    end
endmodule